// File: doc/BRIEF.md
# Fixed-Source Subword Unpacking Engine

This block is one stage of a DMA data path. It serves transfers whose source never moves, such as a peripheral receive register. The source holds packed elements that are narrower than the bus. The engine reads one 32-bit word from that fixed address and splits it into byte or halfword elements. It sends them one by one to the destination write port, and it reads the next word only once the current one has been fully used.

A transfer starts with a one-cycle start pulse that carries the transaction mode, the element type, the element count, the source address and the destination base. The engine runs only when the mode code is 3. Source reads use a request/valid pair. Destination writes use a valid/ready pair and carry a replicated data word and a byte-enable. A one-cycle done pulse marks the end of the transfer.

Top module: `subword_unpack`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `rd_req_o`, `wr_valid_o` and `done_o` are all 0. A start pulse is taken only when idle, with `mode_i` equal to 3 and `count_i` not zero. Any other start causes no read, no write and no done pulse.
- R2: During a fetch, `rd_req_o` stays high with `rd_addr_o` equal to the source address captured at start. Every fetch of the transfer uses that same address. The word on `rd_data_i` is taken in the cycle where `rd_req_o` and `rd_valid_i` are both high.
- R3: Element type code 0 (word) sends each fetched word whole as one element, with byte-enable 4'b1111. Code 3 behaves the same as code 0.
- R4: Type code 1 (halfword) sends bits 15:0 and then bits 31:16 of each word. Type code 2 (byte) sends bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R5: Write data repeats the element across the bus: a byte in all four byte lanes, a halfword in both halves. The byte-enable follows destination address bits 1:0. For a byte it is 4'b0001 shifted left by those bits. For a halfword it is 4'b0011 if bit 1 is 0 and 4'b1100 if bit 1 is 1.
- R6: The k-th element (counting from 0) is written to the destination base plus k times the element size in bytes (1, 2 or 4). Exactly `count_i` elements are written.
- R7: A new source read starts only after the last lane of the current word is accepted. If the count runs out partway through a word, no further read is made. A transfer therefore makes exactly ceil(count / lanes-per-word) reads.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, the write data, address and byte-enable stay unchanged. `wr_valid_o` stays high.
- R9: `done_o` is high for exactly one cycle. That cycle directly follows the cycle in which the last element was accepted. `busy_o` is 0 in the cycle after the done pulse.
- R10: `rd_req_o` and `wr_valid_o` are never high together. A start pulse during a transfer does not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse carrying the transfer setup |
| mode_i | input | 3 | Transaction mode code; 3 selects this engine |
| dtype_i | input | 2 | Element type: 0 word, 1 halfword, 2 byte |
| count_i | input | CNT_W | Number of elements to write |
| src_addr_i | input | ADDR_W | Fixed source address |
| dst_base_i | input | ADDR_W | First destination address |
| rd_req_o | output | 1 | Source read request |
| rd_addr_o | output | ADDR_W | Source read address |
| rd_valid_i | input | 1 | Source read data valid |
| rd_data_i | input | 32 | Source read data |
| wr_valid_o | output | 1 | Destination write valid |
| wr_addr_o | output | ADDR_W | Destination write address |
| wr_data_o | output | 32 | Replicated element data |
| wr_be_o | output | 4 | Destination byte-enable |
| wr_ready_i | input | 1 | Destination ready |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong lane index shows up at the first write that follows it: that write carries bytes from the wrong part of the word, or the wrong byte-enable. A drifting destination pointer shows up as a wrong address on the next accepted write. A wrong remaining count or lane-end decision shows up within one word. The symptom is a read request where a write should follow, a write where a read should follow, or a done pulse at the wrong place in the stream. Back-pressure held at random lengths shows whether the element and the index stay frozen until acceptance.

// File: rtl/subword_unpack_pkg.sv
package subword_unpack_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(BE_W);
  localparam logic [2:0]  MODE_SUBWORD = 3'd3;

  typedef enum logic [1:0] {
    DT_WORD = 2'd0,
    DT_HALF = 2'd1,
    DT_BYTE = 2'd2,
    DT_RSVD = 2'd3
  } dtype_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EMIT,
    ST_DONE
  } state_e;

  // bytes covered by one element
  function automatic logic [2:0] elem_bytes(input dtype_e d);
    case (d)
      DT_HALF: return 3'd2;
      DT_BYTE: return 3'd1;
      default: return 3'd4;
    endcase
  endfunction

  // index of the final lane in a word
  function automatic logic [LANE_W-1:0] lane_last(input dtype_e d);
    case (d)
      DT_HALF: return LANE_W'(1);
      DT_BYTE: return LANE_W'(3);
      default: return '0;
    endcase
  endfunction

  // pick one lane of the word, zero-extended
  function automatic logic [WORD_W-1:0] lane_extract(input logic [WORD_W-1:0] w,
                                                     input dtype_e d,
                                                     input logic [LANE_W-1:0] lane);
    case (d)
      DT_HALF: return {16'b0, (lane[0] ? w[31:16] : w[15:0])};
      DT_BYTE: return {24'b0, w[{lane, 3'b000} +: 8]};
      default: return w;
    endcase
  endfunction

  // spread an element over every lane of the bus
  function automatic logic [WORD_W-1:0] lane_spread(input logic [WORD_W-1:0] v,
                                                    input dtype_e d);
    case (d)
      DT_HALF: return {2{v[15:0]}};
      DT_BYTE: return {4{v[7:0]}};
      default: return v;
    endcase
  endfunction

  // byte-enable from destination address low bits
  function automatic logic [BE_W-1:0] lane_enable(input logic [LANE_W-1:0] a,
                                                  input dtype_e d);
    case (d)
      DT_HALF: return a[1] ? 4'b1100 : 4'b0011;
      DT_BYTE: return 4'b0001 << a;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/su_lane_mux.sv
module su_lane_mux
  import subword_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  dtype_e            dtype_i,
  input  logic [LANE_W-1:0] addr_lsb_i,
  output logic [WORD_W-1:0] data_o,
  output logic [BE_W-1:0]   be_o
);

  always_comb begin
    data_o = lane_spread(lane_extract(word_i, dtype_i, lane_i), dtype_i);
    be_o   = lane_enable(addr_lsb_i, dtype_i);
  end

endmodule

// File: rtl/su_word_hold.sv
module su_word_hold
  import subword_unpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
    end else if (load_i) begin
      word_o <= data_i;
    end
  end

endmodule

// File: rtl/su_seq_ctrl.sv
module su_seq_ctrl
  import subword_unpack_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  dtype_e            dtype_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic              rd_valid_i,
  input  logic              wr_ready_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LANE_W-1:0] lane_o,
  output dtype_e            dtype_o,
  output logic [CNT_W-1:0]  remaining_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ev_fetch_o,
  output logic              ev_write_o,
  output logic              ev_lane_end_o
);

  state_e              state_q, state_d;
  dtype_e              dtype_q;
  logic [CNT_W-1:0]    remaining_q;
  logic [LANE_W-1:0]   lane_q;
  logic [ADDR_W-1:0]   src_q, dst_q;
  logic                start_ok, last_elem;

  assign start_ok      = (state_q == ST_IDLE) && start_i &&
                         (mode_i == MODE_SUBWORD) && (count_i != '0);
  assign ev_fetch_o    = (state_q == ST_FETCH) && rd_valid_i;
  assign ev_write_o    = (state_q == ST_EMIT) && wr_ready_i;
  assign ev_lane_end_o = (lane_q == lane_last(dtype_q));
  assign last_elem     = (remaining_q == CNT_W'(1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_FETCH;
      ST_FETCH: if (ev_fetch_o) state_d = ST_EMIT;
      ST_EMIT: begin
        if (ev_write_o) begin
          if (last_elem)          state_d = ST_DONE;
          else if (ev_lane_end_o) state_d = ST_FETCH;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      dtype_q     <= DT_WORD;
      remaining_q <= '0;
      lane_q      <= '0;
      src_q       <= '0;
      dst_q       <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        dtype_q     <= dtype_i;
        remaining_q <= count_i;
        lane_q      <= '0;
        src_q       <= src_addr_i;
        dst_q       <= dst_base_i;
      end
      if (ev_write_o) begin
        remaining_q <= remaining_q - CNT_W'(1);
        dst_q       <= dst_q + ADDR_W'(elem_bytes(dtype_q));
        lane_q      <= ev_lane_end_o ? '0 : lane_q + LANE_W'(1);
      end
    end
  end

  assign rd_req_o    = (state_q == ST_FETCH);
  assign rd_addr_o   = src_q;
  assign wr_valid_o  = (state_q == ST_EMIT);
  assign wr_addr_o   = dst_q;
  assign lane_o      = lane_q;
  assign dtype_o     = dtype_q;
  assign remaining_o = remaining_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

endmodule

// File: rtl/subword_unpack.sv
module subword_unpack
  import subword_unpack_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        dtype_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_be_o,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              done_o
);

  // named internal events, visible to the bound checker
  logic              ev_fetch, ev_write, ev_lane_end;
  logic [CNT_W-1:0]  remaining;
  logic [LANE_W-1:0] lane;
  dtype_e            dtype_q;
  logic [1:0]        cfg_dtype;
  logic [WORD_W-1:0] held_word;

  su_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .dtype_i      (dtype_e'(dtype_i)),
    .count_i      (count_i),
    .src_addr_i   (src_addr_i),
    .dst_base_i   (dst_base_i),
    .rd_valid_i   (rd_valid_i),
    .wr_ready_i   (wr_ready_i),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .lane_o       (lane),
    .dtype_o      (dtype_q),
    .remaining_o  (remaining),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ev_fetch_o   (ev_fetch),
    .ev_write_o   (ev_write),
    .ev_lane_end_o(ev_lane_end)
  );

  su_word_hold hold_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ev_fetch),
    .data_i(rd_data_i),
    .word_o(held_word)
  );

  su_lane_mux mux_i (
    .word_i    (held_word),
    .lane_i    (lane),
    .dtype_i   (dtype_q),
    .addr_lsb_i(wr_addr_o[LANE_W-1:0]),
    .data_o    (wr_data_o),
    .be_o      (wr_be_o)
  );

  assign cfg_dtype = dtype_q;

endmodule

// File: rtl/subword_unpack_sva.sv
module subword_unpack_sva #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [31:0]       wr_data_o,
  input logic [3:0]        wr_be_o,
  input logic              wr_ready_i,
  input logic              done_o,
  input logic              ev_write,
  input logic              ev_lane_end,
  input logic [CNT_W-1:0]  remaining,
  input logic [1:0]        cfg_dtype
);

  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_valid_o));

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o) &&
                                     $stable(wr_addr_o) && $stable(wr_be_o)));

  a_r2_src_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_write && remaining == CNT_W'(1)) |=> done_o);

  a_r7_stay_in_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_write && !ev_lane_end && remaining != CNT_W'(1)) |=> wr_valid_o);

  a_r7_refetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_write && ev_lane_end && remaining != CNT_W'(1)) |=> rd_req_o);

  a_r5_be_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($countones(wr_be_o) ==
                    ((cfg_dtype == 2'd2) ? 1 : (cfg_dtype == 2'd1) ? 2 : 4)));

endmodule

bind subword_unpack subword_unpack_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .wr_be_o    (wr_be_o),
  .wr_ready_i (wr_ready_i),
  .done_o     (done_o),
  .ev_write   (ev_write),
  .ev_lane_end(ev_lane_end),
  .remaining  (remaining),
  .cfg_dtype  (cfg_dtype)
);

// File: tb/subword_unpack_tb_top.sv
module subword_unpack_tb_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        mode = 3'd0;
  logic [1:0]        dtype = 2'd0;
  logic [CNT_W-1:0]  count = '0;
  logic [ADDR_W-1:0] src_addr = '0;
  logic [ADDR_W-1:0] dst_base = '0;
  logic              rd_req_o, wr_valid_o, busy_o, done_o;
  logic [ADDR_W-1:0] rd_addr_o, wr_addr_o;
  logic [31:0]       wr_data_o;
  logic [3:0]        wr_be_o;
  logic              rd_valid = 1'b0;
  logic [31:0]       rd_data = '0;
  logic              wr_ready = 1'b0;

  always #5 clk = ~clk;

  subword_unpack #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .dtype_i(dtype),
    .count_i(count), .src_addr_i(src_addr), .dst_base_i(dst_base),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid),
    .rd_data_i(rd_data), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .wr_ready_i(wr_ready),
    .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // element size in bytes from the type code (R3, R4)
  function automatic int size_of(input int dt);
    if (dt == 1) return 2;
    if (dt == 2) return 1;
    return 4;
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] s, input int k);
    return (s ^ (32'(k) * 32'h9E3779B1)) + 32'(k);
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] w, input int dt, input int idx);
    int sz;
    int nl;
    int lane;
    logic [31:0] v;
    logic [31:0] r;
    sz = size_of(dt);
    nl = 4 / sz;
    lane = idx % nl;
    v = w >> (lane * sz * 8);
    if (sz < 4) v = v & ((32'd1 << (sz * 8)) - 32'd1);
    r = '0;
    for (int k = 0; k < nl; k++) r = r | (v << (k * sz * 8));
    return r;
  endfunction

  function automatic logic [3:0] exp_be(input logic [31:0] a, input int dt);
    logic [3:0] m;
    m = 4'((1 << size_of(dt)) - 1);
    return m << a[1:0];
  endfunction

  // monitor state
  bit          mon_on = 1'b0;
  int          exp_dtype = 0;
  int          exp_count = 0;
  logic [31:0] exp_base = '0;
  logic [31:0] exp_src = '0;
  logic [31:0] salt = '0;
  int          elem_idx = 0;
  int          fetch_idx = 0;
  int          done_seen = 0;
  int          overlap = 0;
  int          bp_pct = 0;
  int          rv_pct = 100;
  bit          expect_done = 1'b0;
  bit          bp_pend = 1'b0;
  logic [31:0] sv_data, sv_addr;
  logic [3:0]  sv_be;

  always @(negedge clk) begin
    if (mon_on) begin
      if (expect_done) begin
        check(done_o == 1'b1, "R9 done one cycle after last write", 32'(done_o), 32'd1);
        expect_done = 1'b0;
        done_seen++;
      end else if (done_o) begin
        check(1'b0, "R9 unexpected done", 32'(done_o), 32'd0);
      end
      if (rd_req_o && wr_valid_o) overlap++;
      if (bp_pend) begin
        check(wr_valid_o && wr_data_o == sv_data && wr_addr_o == sv_addr && wr_be_o == sv_be,
              "R8 stalled write held", wr_data_o, sv_data);
      end
      // source side
      rd_valid = rd_req_o && (($urandom % 100) < 32'(rv_pct));
      if (rd_valid) begin
        check(rd_addr_o == exp_src, "R2 fixed source address", rd_addr_o, exp_src);
        check((elem_idx % (4 / size_of(exp_dtype))) == 0, "R7 read only at word boundary",
              32'(elem_idx), 32'd0);
        rd_data = word_of(salt, fetch_idx);
        fetch_idx++;
      end
      // destination side
      wr_ready = (($urandom % 100) >= 32'(bp_pct));
      bp_pend = wr_valid_o && !wr_ready;
      sv_data = wr_data_o;
      sv_addr = wr_addr_o;
      sv_be   = wr_be_o;
      if (wr_valid_o && wr_ready) begin
        if (elem_idx >= exp_count) begin
          check(1'b0, "R7 write beyond count", 32'(elem_idx), 32'(exp_count));
        end else begin
          logic [31:0] w;
          logic [31:0] ea;
          w  = word_of(salt, elem_idx / (4 / size_of(exp_dtype)));
          ea = exp_base + 32'(elem_idx * size_of(exp_dtype));
          check(wr_data_o == exp_data(w, exp_dtype, elem_idx),
                (size_of(exp_dtype) == 4) ? "R3 whole word data" : "R4 lane order data",
                wr_data_o, exp_data(w, exp_dtype, elem_idx));
          check(wr_addr_o == ea, "R6 destination address", wr_addr_o, ea);
          check(wr_be_o == exp_be(ea, exp_dtype), "R5 byte enable",
                32'(wr_be_o), 32'(exp_be(ea, exp_dtype)));
          elem_idx++;
          if (elem_idx == exp_count) expect_done = 1'b1;
        end
      end
    end
  end

  task automatic run_xfer(input int dt, input int cnt, input logic [31:0] base,
                          input logic [31:0] src, input int bp, input int rv, input bit mid);
    int nl;
    int cyc;
    nl = 4 / size_of(dt);
    exp_dtype = dt; exp_count = cnt; exp_base = base; exp_src = src;
    salt = $urandom; elem_idx = 0; fetch_idx = 0; done_seen = 0; overlap = 0;
    bp_pct = bp; rv_pct = rv;
    @(negedge clk);
    start = 1'b1; mode = 3'd3; dtype = 2'(dt); count = CNT_W'(cnt);
    src_addr = src; dst_base = base;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (done_seen == 0 && cyc < 3000) begin
      @(negedge clk); #1;
      cyc++;
      if (mid && cyc == 3) begin
        // R10: restart attempt mid-transfer must be ignored
        start = 1'b1; count = count + CNT_W'(5); src_addr = src + 32'd4;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(done_seen == 1, "R9 one done per transfer", 32'(done_seen), 32'd1);
    check(elem_idx == cnt, "R6 element total", 32'(elem_idx), 32'(cnt));
    check(fetch_idx == (cnt + nl - 1) / nl, "R7 read total", 32'(fetch_idx),
          32'((cnt + nl - 1) / nl));
    check(overlap == 0, "R10 read and write never together", 32'(overlap), 32'd0);
    @(negedge clk); #1;
    check(busy_o == 1'b0, "R9 idle after done", 32'(busy_o), 32'd0);
  endtask

  task automatic probe_ignored(input logic [2:0] md, input int cnt, input string tag);
    bit seen;
    exp_count = 0; elem_idx = 0; fetch_idx = 0; done_seen = 0; rv_pct = 100;
    seen = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = md; dtype = 2'd2; count = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (busy_o || rd_req_o || wr_valid_o) seen = 1'b1;
    end
    check(!seen && fetch_idx == 0 && done_seen == 0, tag, 32'(seen), 32'd0);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250129));
    repeat (3) @(negedge clk);
    #1;
    check(!busy_o && !rd_req_o && !wr_valid_o && !done_o, "R1 idle after reset",
          {28'd0, busy_o, rd_req_o, wr_valid_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R1: starts that must be ignored
    probe_ignored(3'd2, 4, "R1 start ignored for address-list mode");
    probe_ignored(3'd0, 4, "R1 start ignored for linear mode");
    probe_ignored(3'd3, 0, "R1 start ignored for zero count");

    // directed corners
    run_xfer(2, 4,  32'h0000_1000, 32'h4000_0010, 0,  100, 1'b0); // R4 one full word of bytes
    run_xfer(2, 5,  32'h0000_2003, 32'h4000_0010, 20, 70,  1'b0); // R7 partial second word, unaligned bytes
    run_xfer(1, 3,  32'h0000_3002, 32'h4000_0020, 30, 60,  1'b0); // R5 halfword at offset 2
    run_xfer(0, 3,  32'h0000_4000, 32'h4000_0030, 10, 50,  1'b0); // R3 word type
    run_xfer(3, 2,  32'h0000_5000, 32'h4000_0030, 0,  100, 1'b0); // R3 reserved code acts as word
    run_xfer(2, 1,  32'h0000_6001, 32'h4000_0040, 0,  100, 1'b0); // R7 single element
    run_xfer(2, 9,  32'h0000_7000, 32'h4000_0050, 90, 40,  1'b0); // R8 heavy back-pressure
    run_xfer(1, 7,  32'h0000_8000, 32'h4000_0060, 20, 80,  1'b1); // R10 restart ignored

    // constrained random
    for (int n = 0; n < 30; n++) begin
      int dt;
      int cnt;
      logic [31:0] base;
      dt   = int'($urandom % 3);
      cnt  = 1 + int'($urandom % 20);
      base = ($urandom & 32'h0000_FFFC) | ($urandom & 32'h3 & ~32'(size_of(dt) - 1));
      run_xfer(dt, cnt, base, 32'h5000_0000 + ($urandom & 32'hFC),
               int'($urandom % 60), 30 + int'($urandom % 71), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule